// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table has one row for each value of the low bits of the branch address, and each row holds one counter for each value of a short global history of recently resolved branch outcomes. A lookup takes a branch address and returns a taken or not-taken guess in the same cycle. The row is picked by the address and the counter within that row is picked by the current global history. The table stores no tag, so unrelated branches whose low address bits match share a row.

When a branch resolves, the pipeline presents its address and real outcome on the update port. The block trains the one counter that the address and the pre-update history select. In the same cycle it shifts the outcome into the youngest bit of the history. The update port follows valid/ready rules. The block never applies back-pressure: `upd_ready` is held high, so every cycle with `upd_valid` high is an accepted update, and a cycle with `upd_valid` low changes no state. The lookup port is a plain combinational query and has no handshake.

Top module: `corr_bpred`

## Requirements
- R1: Reset sets every counter to 1 (weakly not taken) and clears the global history to 0, so every lookup right after reset predicts not taken.
- R2: The row is `pc[3:0]`, giving 16 rows. Address bits above bit 3 play no part, so any two addresses equal in bits 3..0 read and train the same row.
- R3: Each row holds four counters, and the counter used is the one whose column number equals the 2-bit history value. The history's bit 1 holds the older outcome and bit 0 the newest, where 1 means taken.
- R4: An accepted update changes only the one counter at (row of `upd_pc`, history column). All other counters keep their values, and no counter changes in a cycle without an accepted update.
- R5: A taken outcome raises the trained counter by one, saturating at 3. A not-taken outcome lowers it by one, saturating at 0. `lk_taken` is 1 exactly when the selected counter is 2 or 3.
- R6: A counter at 3 needs two not-taken trainings before its prediction turns to not taken, and one such training leaves the prediction at taken.
- R7: Each accepted update shifts the outcome into history bit 0 and moves the old bit 0 into bit 1. Without an accepted update, the history holds.
- R8: The counter trained by an update is chosen with the history value from before that update's shift.
- R9: A lookup made in the same cycle as an update returns the prediction computed from the state before that update.
- R10: `upd_ready` is 1 in every cycle, so the update port never back-pressures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | Address of the branch being predicted |
| lk_taken | output | 1 | Combinational guess for `lk_pc`: 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_ready | output | 1 | Update acceptance, always 1 |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |

## Verification
A lookup and an update can fall in the same cycle, and that includes the case where both use the same row and history column. The bench drives every update with the lookup address set equal to the update address. Just before the clock edge it compares `lk_taken` with a bench model that has not yet applied the update. Between bursts of back-to-back updates, it sweeps all 16 rows with high address bits varied, so that any counter or history bit that moved too early, too late or in the wrong column shows up in the next sweep.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_TOP  = 2'b11;
  localparam ctr_t CTR_BOT  = 2'b00;

  // Saturating step toward the resolved direction.
  function automatic ctr_t ctr_step(ctr_t cur, logic taken);
    ctr_t nxt;
    if (taken) begin
      nxt = (cur == CTR_TOP) ? cur : cur + ctr_t'(1);
    end else begin
      nxt = (cur == CTR_BOT) ? cur : cur - ctr_t'(1);
    end
    return nxt;
  endfunction

  // Upper half of the range means taken.
  function automatic logic ctr_dir(ctr_t cur);
    return cur[CTR_W-1];
  endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_d = bit_in;
    end else begin : g_multi
      assign hist_d = {hist_q[HIST_W-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist = hist_q;

endmodule

// File: rtl/bp_ctr_cell.sv
module bp_ctr_cell
  import bp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic taken,
  output ctr_t q
);

  ctr_t q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= CTR_INIT;
    end else if (en) begin
      q_r <= ctr_step(q_r, taken);
    end
  end

  assign q = q_r;

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int HIST_W = 2,
  localparam int SLOT_W = ROW_W + HIST_W,
  localparam int SLOTS  = 1 << SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  logic                   wr_taken,
  input  logic [SLOT_W-1:0]      rd_slot,
  output ctr_t                   rd_ctr,
  output logic [SLOTS*CTR_W-1:0] ctr_flat
);

  ctr_t cell_q [SLOTS];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_slot == SLOT_W'(s));
      bp_ctr_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (hit),
        .taken (wr_taken),
        .q     (cell_q[s])
      );
      assign ctr_flat[s*CTR_W +: CTR_W] = cell_q[s];
    end
  endgenerate

  assign rd_ctr = cell_q[rd_slot];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ROW_W  = 4,
  parameter int HIST_W = 2,
  localparam int SLOT_W = ROW_W + HIST_W,
  localparam int SLOTS  = 1 << SLOT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic [HIST_W-1:0]      ghist;
  logic [ROW_W-1:0]       lk_row;
  logic [ROW_W-1:0]       upd_row;
  logic                   upd_fire;
  ctr_t                   lk_ctr;
  logic [SLOTS*CTR_W-1:0] ctr_flat;
  logic                   pc_hi_unused;

  // Row select: low address bits, no tag.
  assign lk_row   = lk_pc[ROW_W-1:0];
  assign upd_row  = upd_pc[ROW_W-1:0];
  assign pc_hi_unused = ^{lk_pc[PC_W-1:ROW_W], upd_pc[PC_W-1:ROW_W]};

  // Never stalls the resolving stage.
  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid & upd_ready;

  bp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_fire),
    .bit_in   (upd_taken),
    .hist     (ghist)
  );

  // Training uses the history sampled before this cycle's shift.
  bp_pht #(.ROW_W(ROW_W), .HIST_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (upd_fire),
    .wr_slot  ({upd_row, ghist}),
    .wr_taken (upd_taken),
    .rd_slot  ({lk_row, ghist}),
    .rd_ctr   (lk_ctr),
    .ctr_flat (ctr_flat)
  );

  assign lk_taken = ctr_dir(lk_ctr);

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
  parameter int ROW_W  = 4,
  parameter int HIST_W = 2,
  localparam int SLOT_W = ROW_W + HIST_W,
  localparam int SLOTS  = 1 << SLOT_W,
  localparam int FLAT_W = SLOTS * 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [ROW_W-1:0]  upd_row,
  input logic [HIST_W-1:0] ghist,
  input logic [FLAT_W-1:0] ctr_flat
);

  localparam logic [FLAT_W-1:0] FLAT_INIT = {SLOTS{2'b01}};

  logic              q_vld;
  logic              q_taken;
  logic [SLOT_W-1:0] q_slot;
  logic [HIST_W-1:0] q_hist;
  logic [FLAT_W-1:0] q_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld   <= 1'b0;
      q_taken <= 1'b0;
      q_slot  <= '0;
      q_hist  <= '0;
      q_flat  <= FLAT_INIT;
    end else begin
      q_vld   <= upd_valid;
      q_taken <= upd_taken;
      q_slot  <= {upd_row, ghist};
      q_hist  <= ghist;
      q_flat  <= ctr_flat;
    end
  end

  logic [1:0]        pre_c;
  logic [1:0]        post_c;
  logic [1:0]        want_c;
  logic [FLAT_W-1:0] keep_mask;

  always_comb begin
    pre_c  = q_flat[q_slot*2 +: 2];
    post_c = ctr_flat[q_slot*2 +: 2];
    if (q_taken) want_c = (pre_c == 2'd3) ? 2'd3 : pre_c + 2'd1;
    else         want_c = (pre_c == 2'd0) ? 2'd0 : pre_c - 2'd1;
    keep_mask = '1;
    keep_mask[q_slot*2 +: 2] = 2'b00;
  end

  // R1: state right after reset release
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ghist == '0 && ctr_flat == FLAT_INIT));

  // R5 saturating step; slot chosen with pre-shift history (R8)
  p_sat_train_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> post_c == want_c);

  // R4: neighbours of the trained counter untouched
  p_others_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> (ctr_flat & keep_mask) == (q_flat & keep_mask));

  // R4: no update, no change
  p_idle_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld |-> ctr_flat == q_flat);

  // R7: history shift on an accepted update
  p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> ghist == {q_hist[HIST_W-2:0], q_taken});

  // R7: history holds otherwise
  p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld |-> ghist == q_hist);

endmodule

bind corr_bpred corr_bpred_chk #(.ROW_W(ROW_W), .HIST_W(HIST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_fire),
  .upd_taken (upd_taken),
  .upd_row   (upd_row),
  .ghist     (ghist),
  .ctr_flat  (ctr_flat)
);

// File: tb/corr_bpred_test.sv
module corr_bpred_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic        upd_valid;
  logic        upd_ready;
  logic [31:0] upd_pc;
  logic        upd_taken;

  int checks = 0;
  int errors = 0;
  int ref_ctr [16][4];
  int ref_h;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  corr_bpred uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 4; c++) ref_ctr[r][c] = 1;
    ref_h = 0;
  endtask

  function automatic int ref_pred(logic [31:0] pc);
    return (ref_ctr[pc[3:0]][ref_h] >= 2) ? 1 : 0;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Accepted update; same-cycle lookup of the same address (R9, R10).
  task automatic upd(logic [31:0] pc, logic t);
    int row;
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc    = pc;
    upd_taken = t;
    lk_pc     = pc;
    #1;
    chk("R9 same-cycle lookup", lk_taken, ref_pred(pc));
    chk("R10 ready", upd_ready, 1);
    @(posedge clk);
    row = pc[3:0];
    if (t) ref_ctr[row][ref_h] = (ref_ctr[row][ref_h] == 3) ? 3 : ref_ctr[row][ref_h] + 1;
    else   ref_ctr[row][ref_h] = (ref_ctr[row][ref_h] == 0) ? 0 : ref_ctr[row][ref_h] - 1;
    ref_h = ((ref_h << 1) | (t ? 1 : 0)) & 3;
  endtask

  task automatic go_idle();
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(logic [31:0] pc, string tag, int exp);
    @(negedge clk);
    lk_pc = pc;
    #1;
    chk(tag, lk_taken, exp);
  endtask

  // Sweep every row, varying the unused high address bits (R2).
  task automatic sweep(string tag);
    for (int r = 0; r < 16; r++) begin
      step_lfsr();
      look({lfsr, 12'h5A0, 4'(r)}, tag, ref_pred({28'h0, 4'(r)}));
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; lk_pc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: all rows weakly not taken
    for (int r = 0; r < 16; r++) look({16'hBEEF, 12'h0, 4'(r)}, "R1 reset", 0);

    // R6 hysteresis and R5 top saturation on row 7, history 11 (R3)
    repeat (4) upd(32'h0000_0007, 1'b1);
    go_idle();
    look(32'h0000_0007, "R6 strong taken", 1);
    repeat (2) upd(32'h1230_0007, 1'b1);   // stays at 3 (R5)
    upd(32'h0000_0007, 1'b0);
    upd(32'h0000_0000, 1'b1);
    upd(32'h0000_0000, 1'b1);
    go_idle();
    look(32'h0000_0007, "R6 one miss keeps taken", 1);
    look(32'hFFFF_FFF7, "R2 alias high bits", 1);
    upd(32'h0000_0007, 1'b0);
    upd(32'h0000_0000, 1'b1);
    upd(32'h0000_0000, 1'b1);
    go_idle();
    look(32'h0000_0007, "R6 two misses flip", 0);
    sweep("R3 column by history");

    // R5 bottom saturation on row 9, history 00
    upd(32'h0000_000C, 1'b0);
    upd(32'h0000_000C, 1'b0);
    repeat (4) upd(32'h0000_0009, 1'b0);
    upd(32'h0000_0009, 1'b1);
    upd(32'h0000_000C, 1'b0);
    upd(32'h0000_000C, 1'b0);
    go_idle();
    look(32'h0000_0009, "R5 floor saturation", 0);
    sweep("R5 after floor");

    // R7 and R4: inputs toggle with valid low, nothing moves
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      step_lfsr();
      upd_valid = 1'b0;
      upd_pc    = {16'h0, lfsr};
      upd_taken = lfsr[0];
    end
    sweep("R7 R4 idle no change");

    // Random bursts: R3 R4 R7 R8 against the model
    for (int b = 0; b < 300; b++) begin
      for (int u = 0; u < 6; u++) begin
        step_lfsr();
        upd({lfsr[15:8], 20'h0, lfsr[3:0]}, lfsr[7] ^ lfsr[2] ^ (lfsr[3:0] < 4'd5));
      end
      go_idle();
      sweep("R8 R4 random burst");
    end

    // R1 again after training
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    for (int r = 0; r < 16; r++) look({16'h1357, 12'h0, 4'(r)}, "R1 reset after training", 0);

    finished = 1;
    finish_run();
  end

endmodule